// File: doc/BRIEF.md
# Configurable Bidirectional GPIO Port

This block is one general-purpose I/O port of eight pins that software controls through three registers: a data latch, a direction mask and an option mask. A small register bus (address, write strobe, write data and a combinational read data path) reaches all of them. For every pin the block produces a pad value, a pad output-enable and a pull-up request. It also samples the pad level through a two-stage synchronizer.

The direction bit sets each pin's role, and the option bit's meaning follows from it. On an input pin the option bit chooses between a plain floating input and one with a pull-up and falling-edge interrupt detection. On an output pin it chooses between push-pull drive and open-drain drive. Reading the data address returns a per-bit mix: the latch for output pins and the synchronized pad level for input pins. Edges that are caught set sticky pending bits. Their OR forms the interrupt line, and software clears them by writing ones to a dedicated address.

Top module: `gpio_port`

## Requirements
- R1: After reset the data latch and the direction mask are 00h, the option mask equals parameter OPT_RESET (default 00h), pad_oe is 00h and pending is 00h.
- R2: Register map on addr: 0 data, 1 direction, 2 option, 3 pending. The direction and option registers read back the last value written. Addresses 4 to 7 read 00h and writes to them change nothing.
- R3: A write to address 0 always loads the data latch, even on pins that are inputs. A pin that later becomes an output drives the written value.
- R4: A read of address 0 returns, bit by bit, the latch where the direction bit is 1 and the synchronized pad level where it is 0.
- R5: A change on pin_in shows up in reads exactly two clock edges after it is applied, because it passes through a two-flop synchronizer.
- R6: pull_en[i] is 1 exactly when direction bit i is 0 and option bit i is 1.
- R7: An output pin with option bit 1 (push-pull) has pad_oe[i]=1 and pad_out[i] equal to the latch bit.
- R8: An output pin with option bit 0 (open-drain) has pad_oe[i]=1 only when the latch bit is 0, and pad_out[i] is always 0.
- R9: An input pin (direction 0) always has pad_oe[i]=0 and pad_out[i]=0.
- R10: A falling edge of the synchronized level on an input pin with option bit 1 sets pending bit i on the edge after the falling level reaches the second synchronizer stage. Output pins and floating input pins never set it. irq is the OR of all pending bits.
- R11: A write to address 3 clears each pending bit whose write-data bit is 1 and leaves the others unchanged. When a new edge and a clear reach the same bit in the same cycle, the new edge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| pin_in | input | 8 | Sampled pad levels |
| pad_out | output | 8 | Value driven to the pad |
| pad_oe | output | 8 | Pad driver enable |
| pull_en | output | 8 | Pull-up request per pin |
| irq | output | 1 | OR of pending bits |

## Verification
Several properties are checked on every cycle. Pads never drive high while disabled, and an open-drain pin never drives high. Input pins never drive, and the pull-up never goes to an output pin. A data write lands in the latch, a rising irq follows a detected edge, and a clear takes effect. Other behaviours depend on sequences of stimulus and are shown only by the bench's scenarios. These are the exact two-edge synchronizer latency, the per-bit read mix, and the pad behaviour over a sweep of direction, option and latch patterns. The bench also covers the timing of pending bits and the rule that a latch value written while a pin is an input is driven once the pin becomes an output.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8,
  parameter int AW = 3,
  parameter logic [7:0] OPT_RESET = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pull_en,
  output logic          irq
);
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_DIR  = AW'(1);
  localparam logic [AW-1:0] A_OPT  = AW'(2);
  localparam logic [AW-1:0] A_PEND = AW'(3);

  logic [W-1:0] dlat, dir, opt, pend;
  logic [W-1:0] s1, s2, s3;
  logic [W-1:0] fall, clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlat <= '0;
      dir  <= '0;
      opt  <= W'(OPT_RESET);
    end else if (wr_en) begin
      if (addr == A_DATA) dlat <= wdata;
      if (addr == A_DIR)  dir  <= wdata;
      if (addr == A_OPT)  opt  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign fall = s3 & ~s2 & ~dir & opt;
  assign clr  = (wr_en && addr == A_PEND) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | fall;
  end

  assign irq     = |pend;
  assign pull_en = ~dir & opt;
  assign pad_oe  = dir & (opt | ~dlat);
  assign pad_out = dir & opt & dlat;

  always_comb begin
    case (addr)
      A_DATA:  rdata = (dir & dlat) | (~dir & s2);
      A_DIR:   rdata = dir;
      A_OPT:   rdata = opt;
      A_PEND:  rdata = pend;
      default: rdata = '0;
    endcase
  end

  AST_NO_HIGH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0); // R8
  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & pad_oe & ~opt) == '0); // R8
  AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir) == '0); // R9
  AST_PULL_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_en & dir) == '0); // R6
  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DATA) |=> dlat == $past(wdata)); // R3
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(fall) != '0); // R10
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PEND && (wdata & ~fall) != '0) |=>
      (pend & $past(wdata & ~fall)) == '0); // R11
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int CLK_PERIOD = 10;
  logic       clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, pin_in = 0;
  logic [7:0] rdata, pad_out, pad_oe, pull_en;
  logic       irq;
  int checks = 0, errors = 0, cyc = 0;
  logic done = 0;

  gpio_port dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pull_en(pull_en), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  function automatic logic [7:0] pat(int k);
    case (k)
      0: return 8'h00; 1: return 8'hFF; 2: return 8'h0F; 3: return 8'hF0;
      4: return 8'h55; 5: return 8'hAA; 6: return 8'h33; default: return 8'hC3;
    endcase
  endfunction

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000 && !done) begin
        errors++; checks++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 data", v, 8'h00);
    rd(1, v); chk("R1 dir", v, 8'h00);
    rd(2, v); chk("R1 opt", v, 8'h00);
    rd(3, v); chk("R1 pend", v, 8'h00);
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rst_n = 1;
    @(negedge clk);

    // R3 latch written while input, then driven
    wr(0, 8'hA5);
    chk("R9 oe input", pad_oe, 8'h00);
    wr(2, 8'hFF); wr(1, 8'hFF);
    chk("R3 pad_out", pad_out, 8'hA5);
    chk("R3 oe", pad_oe, 8'hFF);

    // R2 unused addresses
    for (int a = 4; a < 8; a++) begin
      wr(3'(a), 8'h5A);
      rd(3'(a), v); chk("R2 unused", v, 8'h00);
    end
    rd(1, v); chk("R2 dir kept", v, 8'hFF);
    rd(2, v); chk("R2 opt kept", v, 8'hFF);
    rd(0, v); chk("R2 data kept", v, 8'hA5);

    // R5 synchronizer latency, R4 read mix
    wr(1, 8'h00);
    pin_in = 8'h3C;
    @(negedge clk); rd(0, v); chk("R5 one edge", v, 8'h00);
    @(negedge clk); rd(0, v); chk("R5 two edges", v, 8'h3C);
    wr(1, 8'hF0);
    rd(0, v); chk("R4 mix", v, (8'hF0 & 8'hA5) | (8'h0F & 8'h3C));

    // R6 R7 R8 R9 sweep
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 8; c++) begin
          logic [7:0] d, o, l;
          d = pat(a); o = pat(b); l = pat(c);
          wr(1, d); wr(2, o); wr(0, l);
          rd(1, v); chk("R2 dir rb", v, d);
          rd(2, v); chk("R2 opt rb", v, o);
          chk("R6 pull", pull_en, ~d & o);
          chk("R7 R8 R9 oe", pad_oe, (d & o) | (d & ~o & ~l));
          chk("R7 R8 R9 out", pad_out, d & o & l);
          rd(0, v); chk("R4 sweep", v, (d & l) | (~d & 8'h3C));
        end

    // R10 edges, R11 clear
    wr(3, 8'hFF);
    wr(1, 8'hF0); wr(2, 8'h3F);
    pin_in = 8'hFF;
    repeat (4) @(negedge clk);
    wr(3, 8'hFF);
    rd(3, v); chk("R10 no rise pend", v, 8'h00);
    pin_in = 8'h00;
    @(negedge clk); @(negedge clk);
    chk("R10 irq not yet", {7'd0, irq}, 8'h00);
    @(negedge clk);
    chk("R10 irq", {7'd0, irq}, 8'h01);
    rd(3, v); chk("R10 pend", v, 8'h0F);
    wr(3, 8'h01); rd(3, v); chk("R11 clr one", v, 8'h0E);
    wr(3, 8'h00); rd(3, v); chk("R11 clr none", v, 8'h0E);
    wr(3, 8'h0E); rd(3, v); chk("R11 clr all", v, 8'h00);
    chk("R10 irq low", {7'd0, irq}, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule